// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the finite-state controller for a processor that runs each instruction over several clock cycles. The processor has one memory for both instructions and data, and one ALU. On every cycle the block reads the 6-bit opcode from the instruction register. It moves through a fixed chain of states and drives the select, enable and ALU-operation lines that the datapath needs in each step.

It handles word load, word store, register-register ALU instructions, branch-on-equal and jump. It also handles an add-immediate instruction through two dedicated states: one that computes the sum with the immediate, and one that writes the result to the rt register. In the load write-back state the memory-read enable is held high alongside the write-back select. As a result, the memory-read line can stand in for the write-back select on every cycle that writes a register.

An opcode the block does not recognise raises a one-cycle flag while the block is in decode, and the block then returns to fetch. The current state number is brought out so that the surrounding logic and the test can follow the sequence.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the controller in fetch, which is state number 0, at the next clock edge, whatever the current state.
- R2: In fetch (0) the outputs are mem_rd=1, ir_wr=1, pc_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. Fetch is always followed by decode (1).
- R3: In decode (1) the outputs are alu_a_sel=0, alu_b_sel=11 and alu_op=00, which precomputes the branch target.
- R4: Opcode 6'h23 (load) visits states 0,1,2,3,4 and then returns to 0. State 2 drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. State 3 drives mem_rd=1 and addr_sel=1. State 4 drives reg_wr=1, wb_sel=1, mem_rd=1 and dst_sel=0.
- R5: Opcode 6'h2B (store) visits states 0,1,2,5. State 5 drives mem_wr=1 and addr_sel=1.
- R6: Opcode 6'h00 (register ALU) visits states 0,1,6,7. State 6 drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. State 7 drives reg_wr=1, dst_sel=1 and wb_sel=0.
- R7: Opcode 6'h04 (branch) visits states 0,1,8. State 8 drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01. Opcode 6'h02 (jump) visits states 0,1,9. State 9 drives pc_wr=1 and pc_src=10.
- R8: Opcode 6'h08 (add immediate) visits states 0,1,10,11, exactly four cycles. State 10 drives alu_a_sel=1, alu_b_sel=10 and alu_op=00.
- R9: State 11 drives reg_wr=1, dst_sel=0 and wb_sel=0, and then always returns to 0.
- R10: reg_wr is high only in states 4, 7 and 11. Whenever reg_wr is high, mem_rd equals wb_sel.
- R11: Any other opcode in decode raises bad_op for that one cycle, and the next state is fetch. bad_op is low in every other cycle.
- R12: Every output not listed for a state is 0 in that state. mem_wr is never high together with mem_rd or reg_wr, and pc_wr is never high together with pc_wr_cond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write gated by the ALU zero result |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU input A: 0 = PC, 1 = rs register |
| alu_b_sel | output | 2 | ALU input B: 00 rt, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Write register: 0 = rt, 1 = rd |
| bad_op | output | 1 | Unsupported opcode seen in decode |
| state_o | output | 4 | Current state number |

## Verification
The assertions assume that the opcode stays constant from decode until the instruction returns to fetch, as it does when the instruction register is loaded only in fetch. The checks in state 2 and later depend on this. The stimulus changes the opcode only while the controller is in fetch, and it applies reset only between cycles. The bench tries all 64 opcodes in turn, so every state is reached and every unsupported opcode is seen at least once.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W = 6;
    localparam int ST_W = 4;

    localparam logic [OP_W-1:0] OPC_RALU = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OP_W-1:0] OPC_LOAD = 6'h23;
    localparam logic [OP_W-1:0] OPC_STOR = 6'h2B;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MADDR  = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_REXE   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRCH   = 4'd8,
        ST_JUMP   = 4'd9,
        ST_IEXE   = 4'd10,
        ST_IWB    = 4'd11
    } state_t;

    typedef enum logic [2:0] {
        CLS_MEM, CLS_RALU, CLS_BRCH, CLS_JUMP, CLS_IMM, CLS_BAD
    } op_class_t;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_sel;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       reg_wr;
        logic       dst_sel;
    } ctrl_t;

    function automatic op_class_t classify(input logic [OP_W-1:0] op);
        case (op)
            OPC_LOAD, OPC_STOR: return CLS_MEM;
            OPC_RALU:           return CLS_RALU;
            OPC_BEQ:            return CLS_BRCH;
            OPC_JMP:            return CLS_JUMP;
            OPC_ADDI:           return CLS_IMM;
            default:            return CLS_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_t          cur,
    input  logic [OP_W-1:0] opcode,
    output state_t          nxt,
    output logic            bad_op
);
    op_class_t cls;

    always_comb begin
        cls    = classify(opcode);
        nxt    = ST_FETCH;
        bad_op = 1'b0;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (cls)
                    CLS_MEM:  nxt = ST_MADDR;
                    CLS_RALU: nxt = ST_REXE;
                    CLS_BRCH: nxt = ST_BRCH;
                    CLS_JUMP: nxt = ST_JUMP;
                    CLS_IMM:  nxt = ST_IEXE;
                    default: begin
                        nxt    = ST_FETCH;
                        bad_op = 1'b1;
                    end
                endcase
            end
            ST_MADDR: begin
                if (opcode == OPC_LOAD)      nxt = ST_LDRD;
                else if (opcode == OPC_STOR) nxt = ST_STWR;
                else                         nxt = ST_FETCH;
            end
            ST_LDRD:  nxt = ST_LDWB;
            ST_REXE:  nxt = ST_RDONE;
            ST_IEXE:  nxt = ST_IWB;
            default:  nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_outputs.sv
module mc_ctrl_outputs
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: ctl.alu_b_sel = 2'b11;
            ST_MADDR, ST_IEXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_sel = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_RDONE: begin
                ctl.reg_wr  = 1'b1;
                ctl.dst_sel = 1'b1;
            end
            ST_BRCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'b01;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            ST_IWB: ctl.reg_wr = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output logic       pc_wr,
    output logic       pc_wr_cond,
    output logic       addr_sel,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_wr,
    output logic       wb_sel,
    output logic [1:0] pc_src,
    output logic [1:0] alu_op,
    output logic       alu_a_sel,
    output logic [1:0] alu_b_sel,
    output logic       reg_wr,
    output logic       dst_sel,
    output logic       bad_op,
    output logic [3:0] state_o
);
    state_t cur_q, nxt;
    ctrl_t  ctl;

    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_FETCH;
        else     cur_q <= nxt;
    end

    mc_ctrl_next u_next (
        .cur    (cur_q),
        .opcode (opcode),
        .nxt    (nxt),
        .bad_op (bad_op)
    );

    mc_ctrl_outputs u_out (
        .cur (cur_q),
        .ctl (ctl)
    );

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_sel   = ctl.addr_sel;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign wb_sel     = ctl.wb_sel;
    assign pc_src     = ctl.pc_src;
    assign alu_op     = ctl.alu_op;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign reg_wr     = ctl.reg_wr;
    assign dst_sel    = ctl.dst_sel;
    assign state_o    = cur_q;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       wb_sel,
    input logic       reg_wr,
    input logic       bad_op,
    input logic [3:0] state_o
);
    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) rst |=> state_o == 4'd0);

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1);

    // R4
    load_read_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd3 |=> state_o == 4'd4);

    // R8
    imm_exec_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd10 |=> state_o == 4'd11);

    // R9
    imm_wb_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd11 |=> state_o == 4'd0);

    // R10
    wb_read_match_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (mem_rd == wb_sel));

    // R10
    wb_state_only_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (state_o == 4'd4 || state_o == 4'd7 || state_o == 4'd11));

    // R11
    bad_op_decode_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> state_o == 4'd1);

    // R11
    bad_op_return_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |=> (state_o == 4'd0 && $past(opcode) != 6'h00));

    // R12
    mem_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !(mem_rd || reg_wr));

    // R12
    pc_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));
endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .wb_sel     (wb_sel),
    .reg_wr     (reg_wr),
    .bad_op     (bad_op),
    .state_o    (state_o)
);

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, reg_wr, dst_sel, bad_op;
    logic [3:0] state_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
        .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .reg_wr(reg_wr), .dst_sel(dst_sel),
        .bad_op(bad_op), .state_o(state_o)
    );

    // packed as {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,pc_src,alu_op,alu_a_sel,alu_b_sel,reg_wr,dst_sel}
    function automatic logic [15:0] pack(input logic pw, pwc, as, mr, mw, iw, ws,
                                         input logic [1:0] ps, ao,
                                         input logic aa, input logic [1:0] ab,
                                         input logic rw, ds);
        return {pw, pwc, as, mr, mw, iw, ws, ps, ao, aa, ab, rw, ds};
    endfunction

    function automatic logic [15:0] exp_out(input int st);
        case (st)
            0:  return pack(1,0,0,1,0,1,0,2'b00,2'b00,0,2'b01,0,0);
            1:  return pack(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
            2:  return pack(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
            3:  return pack(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
            4:  return pack(0,0,0,1,0,0,1,2'b00,2'b00,0,2'b00,1,0);
            5:  return pack(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
            6:  return pack(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
            7:  return pack(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
            8:  return pack(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
            9:  return pack(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
            10: return pack(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
            11: return pack(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,0);
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input int st);
        case (st)
            0: return "R2 R12";
            1: return "R3 R12";
            2, 3, 4: return "R4 R12";
            5: return "R5 R12";
            6, 7: return "R6 R12";
            8, 9: return "R7 R12";
            10: return "R8 R12";
            default: return "R9 R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_cycle(input int st, input bit exp_bad);
        logic [15:0] outs;
        outs = pack(pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
                    pc_src, alu_op, alu_a_sel, alu_b_sel, reg_wr, dst_sel);
        check("state sequence R4 R5 R6 R7 R8 R11", {12'h0, state_o}, 16'(st));
        check(req_of(st), outs, exp_out(st));
        check("R11 bad_op", {15'h0, bad_op}, {15'h0, exp_bad});
        if (reg_wr === 1'b1)
            check("R10 mem_rd tracks wb_sel", {15'h0, mem_rd}, {15'h0, wb_sel});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seq [5];
        int len;
        bit bad;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset state", {12'h0, state_o}, 16'h0);

        for (int op = 0; op < 64; op++) begin
            bad = 1'b0;
            seq[0] = 0; seq[1] = 1;
            case (op)
                'h23: begin seq[2] = 2; seq[3] = 3; seq[4] = 4; len = 5; end
                'h2B: begin seq[2] = 2; seq[3] = 5; len = 4; end
                'h00: begin seq[2] = 6; seq[3] = 7; len = 4; end
                'h04: begin seq[2] = 8; len = 3; end
                'h02: begin seq[2] = 9; len = 3; end
                'h08: begin seq[2] = 10; seq[3] = 11; len = 4; end
                default: begin len = 2; bad = 1'b1; end
            endcase
            opcode = 6'(op);
            for (int k = 0; k < len; k++) begin
                check_cycle(seq[k], bad && k == 1);
                @(negedge clk);
            end
            // back in fetch after the last state (R9 for add immediate, R11 for bad)
            check("R9 R11 return to fetch", {12'h0, state_o}, 16'h0);
        end

        // R1: reset from inside a load, in state 3
        opcode = 6'h23;
        repeat (3) @(negedge clk);
        check("R1 pre-reset state", {12'h0, state_o}, 16'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-load", {12'h0, state_o}, 16'h0);
        // R1: reset from state 10 of add immediate
        opcode = 6'h08;
        repeat (2) @(negedge clk);
        check("R1 pre-reset state", {12'h0, state_o}, 16'd10);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-addi", {12'h0, state_o}, 16'h0);
        check_cycle(0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule